// File: doc/BRIEF.md
# Broadcast Rank-1 Semiring Matrix Array

This block is a square grid of DIM×DIM accumulate cells. Each cell owns one element of a matrix C, so C stays resident in the cells from the first preload to the final readout. The grid computes C ← A ⊗ B ⊕ C over one of four selectable semirings. The product is formed as a series of outer-product (rank-1) updates. On accepted step s, the caller presents column s of A and row s of B. The column element for grid row i reaches every cell of that row, and the row element for grid column j reaches every cell of that column, in the same cycle. Each cell (i,j) then folds a(i,s) ⊗ b(s,j) into its own element.

There is no skew between cells. The whole product needs exactly DIM accepted steps, and each step uses 2·DIM input scalars across DIM² cells. The caller works in this order:
1. While the grid is idle, load C one row at a time through the write port.
2. Pulse start with a semiring mode. The grid latches that mode for the whole run.
3. Feed DIM steps, each qualified by a valid strobe. Gaps between steps are allowed.
4. Wait for the one-cycle done pulse.
5. Read C back one row at a time through a row-indexed read port.

A later run that skips the preload continues from the resident C.

Top module: `outer_update_array`

## Requirements
- R1: After reset, busy and done are 0 and every element of C reads 0.
- R2: When the grid is idle and loadEn is 1, the clock edge writes loadData into row loadRow of C. Element j of a row vector sits at bits [j*WIDTH +: WIDTH]. readData shows row readRow of C combinationally, in the same layout.
- R3: A start while idle latches modeIn and raises busy at the next edge. A start while busy is ignored, and the run keeps its latched mode.
- R4: At each accepted step (busy and stepValid both 1), cell (i,j) combines its element with a = element i of colA and b = element j of rowB. All cells update at the same edge.
- R5: Mode 0 (sum-product) sets c to the low WIDTH bits of c + a·b, with unsigned operands.
- R6: Mode 1 (min-plus) sets c to min(c, a+b). The unsigned sum saturates to all ones, which stands for infinity.
- R7: Mode 2 (max-plus) sets c to max(c, a+b), using the same saturating sum.
- R8: Mode 3 (max-min) sets c to max(c, min(a,b)).
- R9: After exactly DIM accepted steps, busy falls and done is 1 for exactly one cycle. Both happen at the edge that takes the last step.
- R10: While busy with stepValid low, C and the step count hold, so gaps between steps do not change the result.
- R11: stepValid while idle has no effect, and loadEn while busy has no effect.
- R12: C is kept after done. A new run without a preload accumulates onto the resident values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| modeIn | input | 2 | Semiring select: 0 sum-product, 1 min-plus, 2 max-plus, 3 max-min |
| stepValid | input | 1 | Current colA/rowB pair is a step |
| colA | input | DIM*WIDTH | Column of A, element i drives grid row i |
| rowB | input | DIM*WIDTH | Row of B, element j drives grid column j |
| loadEn | input | 1 | Write one row of C (idle only) |
| loadRow | input | RW | Row index for the write |
| loadData | input | DIM*WIDTH | Row values to write |
| readRow | input | RW | Row index for the read port |
| readData | output | DIM*WIDTH | Current contents of row readRow |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
The bench checks the done pulse at the edge of the last step and confirms it is gone one edge later. A controller off by one in its step count would pulse a cycle early or late, or leave busy set. Idle steps cycles are inserted within runs to catch a design that advances on every cycle. The bench also fires start and loadEn during a run and sends steps while idle; a grid that honoured any of these would switch semiring mid-run or overwrite C. Operands near full scale exercise the sum-product wrap and the saturation at infinity in the two additive modes, where a plain carry-dropping adder would give small wrong values. A final run without preload shows whether C survives done.

// File: rtl/oua_pkg.sv
package oua_pkg;

  typedef enum logic [1:0] {
    MODE_SUMPROD = 2'd0,
    MODE_MINPLUS = 2'd1,
    MODE_MAXPLUS = 2'd2,
    MODE_MAXMIN  = 2'd3
  } semiMode_e;

  typedef struct packed {
    logic stepEn;   // apply one rank-1 update in every cell
    logic writeEn;  // write one preload row
  } ctrlStrobe_t;

endpackage

// File: rtl/oua_ctrl.sv
module oua_ctrl
  import oua_pkg::*;
#(
  parameter int DIM = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  semiMode_e   modeIn,
  input  logic        stepValid,
  input  logic        loadEn,
  output ctrlStrobe_t strobe,
  output semiMode_e   modeQ,
  output logic        busy,
  output logic        done
);

  localparam int CW = (DIM > 1) ? $clog2(DIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIM - 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] countQ;
  logic          stepTaken;
  logic          lastStep;

  assign stepTaken = busyQ && stepValid;
  assign lastStep  = (countQ == LAST);

  always_comb begin
    strobe         = '0;
    strobe.stepEn  = stepTaken;
    strobe.writeEn = !busyQ && loadEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      countQ <= '0;
      modeQ  <= MODE_SUMPROD;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ  <= 1'b1;
          countQ <= '0;
          modeQ  <= modeIn;
        end
      end else if (stepTaken) begin
        if (lastStep) begin
          busyQ  <= 1'b0;
          doneQ  <= 1'b1;
          countQ <= '0;
        end else begin
          countQ <= countQ + 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/oua_cell.sv
module oua_cell
  import oua_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic             wrEn,
  input  semiMode_e        mode,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] cOut
);

  logic [WIDTH-1:0]   cQ;
  logic [WIDTH:0]     sumWide;
  logic [WIDTH-1:0]   sumSat;
  logic [2*WIDTH-1:0] prodWide;
  logic [WIDTH-1:0]   minAB;
  logic [WIDTH-1:0]   nextVal;

  assign sumWide  = {1'b0, aIn} + {1'b0, bIn};
  assign sumSat   = sumWide[WIDTH] ? {WIDTH{1'b1}} : sumWide[WIDTH-1:0];
  assign prodWide = aIn * bIn;
  assign minAB    = (aIn < bIn) ? aIn : bIn;

  always_comb begin
    unique case (mode)
      MODE_SUMPROD: nextVal = cQ + prodWide[WIDTH-1:0];
      MODE_MINPLUS: nextVal = (sumSat < cQ) ? sumSat : cQ;
      MODE_MAXPLUS: nextVal = (sumSat > cQ) ? sumSat : cQ;
      MODE_MAXMIN:  nextVal = (minAB > cQ) ? minAB : cQ;
      default:      nextVal = cQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cQ <= '0;
    end else if (wrEn) begin
      cQ <= loadVal;
    end else if (stepEn) begin
      cQ <= nextVal;
    end
  end

  assign cOut = cQ;

endmodule

// File: rtl/oua_datapath.sv
module oua_datapath
  import oua_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  semiMode_e                  mode,
  input  logic [DIM*WIDTH-1:0]       colA,
  input  logic [DIM*WIDTH-1:0]       rowB,
  input  logic [((DIM>1)?$clog2(DIM):1)-1:0] loadRow,
  input  logic [DIM*WIDTH-1:0]       loadData,
  input  logic [((DIM>1)?$clog2(DIM):1)-1:0] readRow,
  output logic [DIM*WIDTH-1:0]       readData
);

  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1;

  logic [WIDTH-1:0] cMat [DIM][DIM];
  logic [DIM-1:0]   rowHit;

  for (genvar r = 0; r < DIM; r++) begin : g_rowSel
    assign rowHit[r] = strobe.writeEn && (loadRow == RW'(r));
  end

  for (genvar i = 0; i < DIM; i++) begin : g_row
    for (genvar j = 0; j < DIM; j++) begin : g_col
      oua_cell #(.WIDTH(WIDTH)) u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .stepEn  (strobe.stepEn),
        .wrEn    (rowHit[i]),
        .mode    (mode),
        .aIn     (colA[i*WIDTH +: WIDTH]),
        .bIn     (rowB[j*WIDTH +: WIDTH]),
        .loadVal (loadData[j*WIDTH +: WIDTH]),
        .cOut    (cMat[i][j])
      );
    end
  end

  always_comb begin
    readData = '0;
    for (int r = 0; r < DIM; r++) begin
      if (readRow == RW'(r)) begin
        for (int j = 0; j < DIM; j++) begin
          readData[j*WIDTH +: WIDTH] = cMat[r][j];
        end
      end
    end
  end

endmodule

// File: rtl/outer_update_array.sv
module outer_update_array
  import oua_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int WIDTH = 16,
  localparam int RW   = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           modeIn,
  input  logic                 stepValid,
  input  logic [DIM*WIDTH-1:0] colA,
  input  logic [DIM*WIDTH-1:0] rowB,
  input  logic                 loadEn,
  input  logic [RW-1:0]        loadRow,
  input  logic [DIM*WIDTH-1:0] loadData,
  input  logic [RW-1:0]        readRow,
  output logic [DIM*WIDTH-1:0] readData,
  output logic                 busy,
  output logic                 done
);

  ctrlStrobe_t strobe;
  semiMode_e   modeQ;

  oua_ctrl #(.DIM(DIM)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeIn    (semiMode_e'(modeIn)),
    .stepValid (stepValid),
    .loadEn    (loadEn),
    .strobe    (strobe),
    .modeQ     (modeQ),
    .busy      (busy),
    .done      (done)
  );

  oua_datapath #(.DIM(DIM), .WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mode     (modeQ),
    .colA     (colA),
    .rowB     (rowB),
    .loadRow  (loadRow),
    .loadData (loadData),
    .readRow  (readRow),
    .readData (readData)
  );

endmodule

// File: rtl/oua_checker.sv
module oua_checker #(
  parameter int DIM   = 4,
  parameter int WIDTH = 16,
  localparam int RW   = (DIM > 1) ? $clog2(DIM) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 stepValid,
  input logic                 loadEn,
  input logic [RW-1:0]        readRow,
  input logic [DIM*WIDTH-1:0] readData,
  input logic                 busy,
  input logic                 done
);

  localparam int SW = $clog2(DIM + 1) + 1;

  logic [SW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (start && !busy) begin
      stepCnt <= '0;
    end else if (busy && stepValid) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);  // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));  // R9

  AST_DONE_AFTER_DIM_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stepCnt == SW'(DIM)));  // R9

  AST_GAP_HOLDS_C: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stepValid) |=> (!$stable(readRow) || $stable(readData)));  // R10

  AST_IDLE_HOLDS_C: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !loadEn) |=> (!$stable(readRow) || $stable(readData)));  // R11

endmodule

bind outer_update_array oua_checker #(.DIM(DIM), .WIDTH(WIDTH)) u_oua_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .stepValid (stepValid),
  .loadEn    (loadEn),
  .readRow   (readRow),
  .readData  (readData),
  .busy      (busy),
  .done      (done)
);

// File: tb/outer_update_array_bench.sv
`timescale 1ns/1ps
module outer_update_array_bench;

  localparam int DIM = 4;
  localparam int W   = 16;
  localparam int RW  = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [1:0]         modeIn = '0;
  logic               stepValid = 1'b0;
  logic [DIM*W-1:0]   colA = '0;
  logic [DIM*W-1:0]   rowB = '0;
  logic               loadEn = 1'b0;
  logic [RW-1:0]      loadRow = '0;
  logic [DIM*W-1:0]   loadData = '0;
  logic [RW-1:0]      readRow = '0;
  logic [DIM*W-1:0]   readData;
  logic               busy;
  logic               done;

  always #2.5 clk = ~clk;

  outer_update_array #(.DIM(DIM), .WIDTH(W)) u_outer_update_array (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .stepValid(stepValid), .colA(colA), .rowB(rowB),
    .loadEn(loadEn), .loadRow(loadRow), .loadData(loadData),
    .readRow(readRow), .readData(readData), .busy(busy), .done(done)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  logic [W-1:0] model [DIM][DIM];

  typedef struct {
    int             row;
    logic [DIM*W-1:0] exp;
    string          req;
  } sbItem_t;

  sbItem_t sbQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refOp(input int m, input logic [W-1:0] c,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] ss;
    logic [2*W-1:0] p;
    logic [W-1:0] mn;
    s  = {1'b0, a} + {1'b0, b};
    ss = s[W] ? {W{1'b1}} : s[W-1:0];
    p  = a * b;
    mn = (a < b) ? a : b;
    case (m)
      0: return c + p[W-1:0];
      1: return (ss < c) ? ss : c;
      2: return (ss > c) ? ss : c;
      default: return (mn > c) ? mn : c;
    endcase
  endfunction

  function automatic logic [W-1:0] genVal(input int seed, input int s, input int k);
    return W'(seed * 32'h1357 + s * 32'h0F1 + k * 32'h2B3 + seed * k * 32'h91);
  endfunction

  // monitor: compares each pushed row against readData
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        sbItem_t it;
        it = sbQ.pop_front();
        for (int j = 0; j < DIM; j++) begin
          check(readData[j*W +: W] == it.exp[j*W +: W], it.req,
                $sformatf("C[%0d][%0d]", it.row, j),
                longint'(readData[j*W +: W]), longint'(it.exp[j*W +: W]));
        end
      end
    end
  end

  task automatic verifyAll(input string req);
    for (int r = 0; r < DIM; r++) begin
      sbItem_t it;
      @(posedge clk); #1;
      readRow = RW'(r);
      it.row = r;
      it.req = req;
      for (int j = 0; j < DIM; j++) it.exp[j*W +: W] = model[r][j];
      sbQ.push_back(it);
    end
    @(posedge clk); #1;
  endtask

  task automatic preload(input int seed);
    for (int r = 0; r < DIM; r++) begin
      @(posedge clk); #1;
      loadEn  = 1'b1;
      loadRow = RW'(r);
      for (int j = 0; j < DIM; j++) begin
        loadData[j*W +: W] = genVal(seed, 100 + r, j);
        model[r][j]        = genVal(seed, 100 + r, j);
      end
    end
    @(posedge clk); #1;
    loadEn = 1'b0;
  endtask

  task automatic preloadConst(input logic [W-1:0] v);
    for (int r = 0; r < DIM; r++) begin
      @(posedge clk); #1;
      loadEn  = 1'b1;
      loadRow = RW'(r);
      for (int j = 0; j < DIM; j++) begin
        loadData[j*W +: W] = v;
        model[r][j]        = v;
      end
    end
    @(posedge clk); #1;
    loadEn = 1'b0;
  endtask

  // one full run; gaps inserts an idle cycle after every step; disturb
  // pulses start (other mode) and loadEn during step 1
  task automatic doRun(input int mode, input int seed, input bit gaps,
                       input bit disturb, input string req);
    @(posedge clk); #1;
    start  = 1'b1;
    modeIn = 2'(mode);
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R3", "busy after start", longint'(busy), 1);
    for (int s = 0; s < DIM; s++) begin
      logic [W-1:0] av [DIM];
      logic [W-1:0] bv [DIM];
      stepValid = 1'b1;
      for (int k = 0; k < DIM; k++) begin
        av[k] = genVal(seed, s, k);
        bv[k] = genVal(seed + 7, s, k + 3);
        colA[k*W +: W] = av[k];
        rowB[k*W +: W] = bv[k];
      end
      if (disturb && s == 1) begin
        start    = 1'b1;
        modeIn   = 2'(mode ^ 1);
        loadEn   = 1'b1;
        loadRow  = '0;
        loadData = {DIM*W{1'b1}};
      end
      @(posedge clk); #1;
      start  = 1'b0;
      loadEn = 1'b0;
      for (int i = 0; i < DIM; i++)
        for (int j = 0; j < DIM; j++)
          model[i][j] = refOp(mode, model[i][j], av[i], bv[j]);
      if (s == DIM - 1) begin
        check(done == 1'b1, "R9", "done at last step", longint'(done), 1);
        check(busy == 1'b0, "R9", "busy after last step", longint'(busy), 0);
      end else begin
        check(done == 1'b0, "R9", "done early", longint'(done), 0);
        check(busy == 1'b1, "R9", "busy mid-run", longint'(busy), 1);
      end
      stepValid = 1'b0;
      if (gaps && s != DIM - 1) begin
        colA = {DIM{16'hA5C3}};
        rowB = {DIM{16'h3C5A}};
        @(posedge clk); #1;
        check(busy == 1'b1, "R10", "busy during gap", longint'(busy), 1);
      end
    end
    @(posedge clk); #1;
    check(done == 1'b0, "R9", "done single cycle", longint'(done), 0);
    verifyAll(req);
  endtask

  initial begin
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) model[i][j] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(busy == 1'b0, "R1", "busy after reset", longint'(busy), 0);
    verifyAll("R1");

    // R2: preload and readback
    preload(3);
    verifyAll("R2");

    // R4/R5: sum-product with gaps (R10)
    doRun(0, 5, 1'b1, 1'b0, "R5");

    // R11: steps while idle are ignored
    @(posedge clk); #1;
    stepValid = 1'b1;
    colA = {DIM{16'h7777}};
    rowB = {DIM{16'h1111}};
    repeat (2) @(posedge clk);
    #1;
    stepValid = 1'b0;
    check(busy == 1'b0, "R11", "idle steps start nothing", longint'(busy), 0);
    verifyAll("R11");

    // R6: min-plus from infinity, start/load disturbance mid-run (R3, R11)
    preloadConst(16'hFFFF);
    doRun(1, 9, 1'b0, 1'b1, "R6");

    // R7: max-plus with large operands (saturation)
    preload(11);
    doRun(2, 40, 1'b1, 1'b0, "R7");

    // R8: max-min
    preloadConst(16'h0000);
    doRun(3, 21, 1'b0, 1'b0, "R8");

    // R12/R4: new run without preload accumulates onto resident C
    doRun(0, 2, 1'b0, 1'b0, "R12");

    repeat (DIM + 2) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule